// File: doc/BRIEF.md
# Sparse-Carry Parallel-Prefix Adder

This block adds two operands and a carry-in and returns the sum, the carry-out and a signed overflow flag. It is purely combinational. Carries are resolved by a Kogge-Stone parallel-prefix tree that works only on group boundaries, one boundary every `GRP` bits. Between those boundaries, short ripple segments form the sum bits.

The operand is split into `WIDTH/GRP` groups. Each group, except the top one, folds its bits into one generate/propagate pair. The bottom group also folds in the external carry-in, so it needs no combine cell of its own. The prefix tree turns these pairs into the carry entering every group above the bottom one. The top group never feeds a later group, so its pair is never built.

Each segment either ripples its carry across its bits or, when `CSEL` is set, computes its sum for both carry-in values and picks one with the boundary carry. The segment width is chosen from 4, 8 or 16, and 4 is the default.

Top module: `kpx_sparse_adder`

## Requirements
- R1: `sum` equals the low `WIDTH` bits of `opa + opb + cin`.
- R2: `cout` equals bit `WIDTH` of `opa + opb + cin`.
- R3: `ovf` is 1 exactly when `opa` and `opb` have the same sign bit and the sign bit of `sum` differs from it. Example: 0x7FFFFFFF plus 1 gives `ovf` = 1 and `sum` = 0x80000000.
- R4: The carry entering each group boundary (bit positions k*GRP) equals the true carry into that bit. A carry-in of 1 added to an all-ones operand and a zero operand passes through every group, giving `sum` = 0 and `cout` = 1.
- R5: `GRP` may be 4, 8 or 16, with a default of 4. Every legal value gives the same `sum`, `cout` and `ovf` for the same inputs.
- R6: With `CSEL` = 1, each segment selects between two precomputed sums. The results are identical to the ripple variant.
- R7: The outputs depend only on the current inputs, with no clock and no state. All-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| ovf | output | 1 | Two's-complement overflow |

## Verification
The bench builds four copies side by side:
- group width 4 with ripple segments (the default);
- group width 8 with ripple segments;
- group width 16 with ripple segments;
- group width 8 with carry-select segments.

Together they cover a prefix tree of three levels, of two levels and of no combine level at all, and both segment variants. Directed vectors drive carries across every boundary and into the sign bit. Random vectors mix propagate and generate patterns across groups.

// File: rtl/kpx_pkg.sv
package kpx_pkg;

    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

    function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.gen  = hi.gen | (hi.prop & lo.gen);
        r.prop = hi.prop & lo.prop;
        return r;
    endfunction

    function automatic pg_t pg_bit(input logic x, input logic y);
        pg_t r;
        r.gen  = x & y;
        r.prop = x ^ y;
        return r;
    endfunction

endpackage

// File: rtl/kpx_group_pg.sv
module kpx_group_pg
    import kpx_pkg::*;
#(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] a,
    input  logic [GRP-1:0] b,
    input  logic           seed,
    output pg_t            grp
);
    always_comb begin
        pg_t acc;
        acc.gen  = seed;
        acc.prop = 1'b1;
        for (int i = 0; i < GRP; i++) begin
            acc = pg_merge(pg_bit(a[i], b[i]), acc);
        end
        grp = acc;
    end
endmodule

// File: rtl/kpx_prefix.sv
module kpx_prefix
    import kpx_pkg::*;
#(
    parameter int N = 7
) (
    input  pg_t          leaf [N],
    output logic [N-1:0] carry
);
    localparam int LVL = (N > 1) ? $clog2(N) : 0;

    pg_t node [LVL+1][N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            node[0][i] = leaf[i];
        end
        for (int l = 0; l < LVL; l++) begin
            for (int i = 0; i < N; i++) begin
                if (i >= (1 << l)) begin
                    node[l+1][i] = pg_merge(node[l][i], node[l][i - (1 << l)]);
                end else begin
                    node[l+1][i] = node[l][i];
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            carry[i] = node[LVL][i].gen;
        end
    end
endmodule

// File: rtl/kpx_ripple.sv
module kpx_ripple
    import kpx_pkg::*;
#(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] a,
    input  logic [GRP-1:0] b,
    input  logic           ci,
    output logic [GRP-1:0] s,
    output logic           co
);
    always_comb begin
        logic c;
        pg_t  t;
        c = ci;
        for (int i = 0; i < GRP; i++) begin
            t    = pg_bit(a[i], b[i]);
            s[i] = t.prop ^ c;
            c    = t.gen | (t.prop & c);
        end
        co = c;
    end
endmodule

// File: rtl/kpx_segment.sv
module kpx_segment #(
    parameter int GRP  = 4,
    parameter bit CSEL = 1'b0
) (
    input  logic [GRP-1:0] a,
    input  logic [GRP-1:0] b,
    input  logic           ci,
    output logic [GRP-1:0] s,
    output logic           co
);
    generate
        if (CSEL) begin : g_select
            logic [GRP-1:0] s_lo, s_hi;
            logic           co_lo, co_hi;
            kpx_ripple #(.GRP(GRP)) u_c0 (
                .a(a), .b(b), .ci(1'b0), .s(s_lo), .co(co_lo)
            );
            kpx_ripple #(.GRP(GRP)) u_c1 (
                .a(a), .b(b), .ci(1'b1), .s(s_hi), .co(co_hi)
            );
            assign s  = ci ? s_hi  : s_lo;
            assign co = ci ? co_hi : co_lo;
        end else begin : g_ripple
            kpx_ripple #(.GRP(GRP)) u_rc (
                .a(a), .b(b), .ci(ci), .s(s), .co(co)
            );
        end
    endgenerate
endmodule

// File: rtl/kpx_sparse_adder.sv
module kpx_sparse_adder
    import kpx_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int GRP   = 4,
    parameter bit CSEL  = 1'b0
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int NG = WIDTH / GRP;
    localparam int NP = NG - 1;

    pg_t               grp_pg [NP];
    logic [NP-1:0]     pfx_c;
    logic [NG-1:0]     grp_cin;
    logic [NG-1:0]     seg_co;

    genvar k;
    generate
        for (k = 0; k < NP; k++) begin : g_pg
            kpx_group_pg #(.GRP(GRP)) u_gpg (
                .a   (opa[k*GRP +: GRP]),
                .b   (opb[k*GRP +: GRP]),
                .seed((k == 0) ? cin : 1'b0),
                .grp (grp_pg[k])
            );
        end
    endgenerate

    kpx_prefix #(.N(NP)) u_pfx (
        .leaf (grp_pg),
        .carry(pfx_c)
    );

    assign grp_cin = {pfx_c, cin};

    generate
        for (k = 0; k < NG; k++) begin : g_seg
            kpx_segment #(.GRP(GRP), .CSEL(CSEL)) u_seg (
                .a (opa[k*GRP +: GRP]),
                .b (opb[k*GRP +: GRP]),
                .ci(grp_cin[k]),
                .s (sum[k*GRP +: GRP]),
                .co(seg_co[k])
            );
        end
    endgenerate

    assign cout = seg_co[NG-1];
    assign ovf  = (opa[WIDTH-1] == opb[WIDTH-1]) && (sum[WIDTH-1] != opa[WIDTH-1]);
endmodule

// File: rtl/kpx_sparse_adder_chk.sv
module kpx_sparse_adder_chk #(
    parameter int WIDTH = 32,
    parameter int GRP   = 4
) (
    input logic [WIDTH-1:0]       opa,
    input logic [WIDTH-1:0]       opb,
    input logic                   cin,
    input logic [WIDTH-1:0]       sum,
    input logic                   cout,
    input logic                   ovf,
    input logic [WIDTH/GRP-1:0]   grp_cin,
    input logic [WIDTH/GRP-1:0]   seg_co
);
    localparam int NG = WIDTH / GRP;

    logic [WIDTH:0] ref_sum;
    logic [WIDTH:0] ref_car;

    always_comb begin
        ref_sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
        ref_car = ref_sum ^ {1'b0, opa} ^ {1'b0, opb};
        if (!$isunknown({opa, opb, cin})) begin
            AST_SUM_REF: assert (sum == ref_sum[WIDTH-1:0]);          // R1
            AST_COUT_REF: assert (cout == ref_sum[WIDTH]);            // R2
            AST_OVF_SIGN: assert (ovf == (ref_car[WIDTH-1] ^ ref_car[WIDTH])); // R3
            for (int k = 0; k < NG; k++) begin
                AST_GRP_CARRY: assert (grp_cin[k] == ref_car[k*GRP]); // R4
                AST_SEG_HANDOFF: assert (seg_co[k] == ref_car[(k+1)*GRP]); // R4
            end
        end
    end
endmodule

bind kpx_sparse_adder kpx_sparse_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) u_chk (
    .opa(opa), .opb(opb), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf),
    .grp_cin(grp_cin), .seg_co(seg_co)
);

// File: tb/kpx_sparse_adder_test.sv
module kpx_sparse_adder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [31:0] opa = '0, opb = '0;
    logic        cin = 1'b0;

    logic [31:0] s4, s8, s16, scs;
    logic        c4, c8, c16, ccs, v4, v8, v16, vcs;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    kpx_sparse_adder uut (
        .opa(opa), .opb(opb), .cin(cin), .sum(s4), .cout(c4), .ovf(v4));
    kpx_sparse_adder #(.GRP(8)) uut_g8 (
        .opa(opa), .opb(opb), .cin(cin), .sum(s8), .cout(c8), .ovf(v8));
    kpx_sparse_adder #(.GRP(16)) uut_g16 (
        .opa(opa), .opb(opb), .cin(cin), .sum(s16), .cout(c16), .ovf(v16));
    kpx_sparse_adder #(.GRP(8), .CSEL(1'b1)) uut_cs (
        .opa(opa), .opb(opb), .cin(cin), .sum(scs), .cout(ccs), .ovf(vcs));

    function automatic logic [32:0] exp_add(input logic [31:0] x, input logic [31:0] y,
                                            input logic c);
        return {1'b0, x} + {1'b0, y} + {32'd0, c};
    endfunction

    function automatic logic exp_ovf(input logic [31:0] x, input logic [31:0] y,
                                     input logic c);
        logic [32:0] r;
        r = exp_add(x, y, c);
        return (x[31] == y[31]) && (r[31] != x[31]);
    endfunction

    task automatic cmp_one(input string inst, input string tag,
                           input logic [31:0] s, input logic co, input logic ov,
                           input logic [32:0] e, input logic eo);
        n_chk++;
        if (s !== e[31:0]) begin
            n_fail++;
            $display("FAIL R1 %s %s sum actual=%h expected=%h", inst, tag, s, e[31:0]);
        end
        if (co !== e[32]) begin
            n_fail++;
            $display("FAIL R2 %s %s cout actual=%b expected=%b", inst, tag, co, e[32]);
        end
        if (ov !== eo) begin
            n_fail++;
            $display("FAIL R3 %s %s ovf actual=%b expected=%b", inst, tag, ov, eo);
        end
    endtask

    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic c,
                         input string tag);
        logic [32:0] e;
        logic        eo;
        @(posedge clk);
        opa <= x; opb <= y; cin <= c;
        @(negedge clk);
        e  = exp_add(x, y, c);
        eo = exp_ovf(x, y, c);
        cmp_one("grp4",        tag,              s4,  c4,  v4,  e, eo);
        cmp_one("grp8 R5",     tag,              s8,  c8,  v8,  e, eo);
        cmp_one("grp16 R5",    tag,              s16, c16, v16, e, eo);
        cmp_one("grp8sel R6",  tag,              scs, ccs, vcs, e, eo);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: zero inputs give zero outputs, no state involved
        n_chk++;
        if ({s4, c4, v4} !== '0) begin
            n_fail++;
            $display("FAIL R7 reset-phase outputs actual=%h expected=0", {s4, c4, v4});
        end
        rst = 1'b0;

        apply(32'h0000_0000, 32'h0000_0000, 1'b0, "R7 zeros");
        apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R4 all-ones plus cin");
        apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R4 all-ones plus one");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2 max carry");
        apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R3 max positive plus one");
        apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 negative overflow");
        apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R3 mixed sign no overflow");
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R1 alternating");
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R4 alternating ripple");
        apply(32'h5555_5555, 32'h5555_5555, 1'b0, "R1 alternating double");
        for (int k = 1; k < 8; k++) begin
            apply((32'h1 << (4*k)) - 32'h1, 32'h1, 1'b0, "R4 boundary carry");
        end
        apply(32'h0000_FFFF, 32'h0000_0000, 1'b1, "R5 half-word boundary");
        apply(32'h00FF_00FF, 32'h0001_0001, 1'b0, "R5 byte boundaries");
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] x, y;
            x = $urandom();
            y = $urandom();
            case (i % 4)
                0: y = ~x;
                1: y = ~x ^ (32'h1 << (i % 32));
                default: ;
            endcase
            apply(x, y, 1'($urandom() & 1), "R1 random");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (cyc < 100000 && !done) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule